// File: doc/BRIEF.md
# Parallel I/O Port with Edge-Capture Interrupt

This block is a parallel I/O port of up to 32 pins. A host reaches it through a small word-indexed register bus with four registers. Through these it sets each pin's direction and the value the pin drives, reads the pin levels, and picks which pins may raise an interrupt. Pin inputs pass through a two-stage synchronizer. The synchronized level is what the host reads and what drives event detection.

The trigger behaviour is fixed when the block is elaborated. There are three edge modes: rising, falling, or both. In these, each detected edge sets a sticky capture bit that stays set until the host writes a one to it. In level mode the interrupt follows the unmasked pin levels directly, and the capture register stays empty. The block has a single interrupt output, which combines every enabled source. A service routine can clear the capture bits it handled and then check the line again, until it drops.

The register bus carries no data stream, so it has no valid/ready handshake and no back-pressure. A write takes effect in one cycle. A read is combinational from the register index in the same cycle.

Top module: `gpio_capture_port`

## Requirements
- R1: Reset clears the direction register, the interrupt-enable register, the output latch and the capture register. After reset every register reads zero while the pins are low, pin_oe is zero and irq is low.
- R2: The register index bus_addr selects a register: 0 is pin data (byte offset 0x0), 1 is direction (0x4), 2 is interrupt enable (0x8) and 3 is capture (0xC). Read bits at and above NUM_PINS return zero.
- R3: A direction bit of 1 makes its pin an output, and pin_oe follows the direction register. A write to index 0 loads the output latch, which appears on pin_out in the next cycle.
- R4: A read of index 0 returns the synchronized pin levels and not the output latch. A pin change becomes visible there after two rising clock edges.
- R5: In rising mode a capture bit sets only on a 0-to-1 change of its synchronized pin. In falling mode it sets only on a 1-to-0 change. The bit is visible one edge after the synchronized level changes, which is three edges after the pin changes.
- R6: In both-edges mode a capture bit sets on either direction of change.
- R7: A write to index 3 clears exactly the capture bits written as 1 and leaves the others unchanged.
- R8: If a new edge and a clearing write reach the same capture bit on the same clock edge, the bit stays set.
- R9: In edge modes, irq is high exactly while some capture bit is set and its enable bit is 1. Disabling a pin hides its capture bit without clearing it.
- R10: In level mode, irq is high while some synchronized pin is high with its enable bit 1. The capture register reads zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register index (byte offset divided by four) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at bus_addr |
| pin_in | input | NUM_PINS | Raw pin levels |
| pin_out | output | NUM_PINS | Output latch driven to the pads |
| pin_oe | output | NUM_PINS | Per-pin output enable (direction) |
| irq | output | 1 | Combined interrupt request |

## Verification
Register writes are due one edge after the strobe, and reads follow bus_addr in the same cycle. A pin change shows in the data register after two edges and in the capture register after three. In level mode it reaches irq after two edges. Every stimulus is applied just after a rising edge, and the bench counts edges explicitly before it queues each expectation. It also samples once before the due edge, so a result that arrives early is caught as well. The set-over-clear case is timed so that the clearing write is sampled on exactly the edge that captures the new event.

// File: rtl/gpio_cap_pkg.sv
package gpio_cap_pkg;
  typedef enum logic [1:0] {
    TRIG_RISE  = 2'd0,
    TRIG_FALL  = 2'd1,
    TRIG_BOTH  = 2'd2,
    TRIG_LEVEL = 2'd3
  } trig_e;

  localparam int BUS_W = 32;
  localparam int SEL_W = 2;

  localparam logic [SEL_W-1:0] SEL_DATA = 2'd0;
  localparam logic [SEL_W-1:0] SEL_DIR  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_MASK = 2'd2;
  localparam logic [SEL_W-1:0] SEL_CAP  = 2'd3;
endpackage

// File: rtl/gpio_cap_sync.sv
module gpio_cap_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_sync,
  output logic [WIDTH-1:0] q_prev
);
  logic [WIDTH-1:0] meta_q;

  // two metastability stages, then one history stage for edge compare
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_sync <= '0;
      q_prev <= '0;
    end else begin
      meta_q <= d_in;
      q_sync <= meta_q;
      q_prev <= q_sync;
    end
  end
endmodule

// File: rtl/gpio_cap_event.sv
module gpio_cap_event import gpio_cap_pkg::*; #(
  parameter int    WIDTH = 32,
  parameter trig_e TRIG  = TRIG_RISE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] prev,
  input  logic             clr_en,
  input  logic [WIDTH-1:0] clr_bits,
  output logic [WIDTH-1:0] hit,
  output logic [WIDTH-1:0] cap_q
);
  logic [WIDTH-1:0] up_w;
  logic [WIDTH-1:0] down_w;

  assign up_w   = cur & ~prev;
  assign down_w = ~cur & prev;

  always_comb begin
    case (TRIG)
      TRIG_RISE: hit = up_w;
      TRIG_FALL: hit = down_w;
      TRIG_BOTH: hit = up_w | down_w;
      default:   hit = '0;   // level mode never captures
    endcase
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cap_q[i] <= 1'b0;
      else if (hit[i])
        cap_q[i] <= 1'b1;          // a fresh event beats a clear
      else if (clr_en && clr_bits[i])
        cap_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_capture_port.sv
module gpio_capture_port import gpio_cap_pkg::*; #(
  parameter int    NUM_PINS = 32,
  parameter trig_e TRIG     = TRIG_RISE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [SEL_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  localparam bit LEVEL_MODE = (TRIG == TRIG_LEVEL);

  logic [NUM_PINS-1:0] sync_q;
  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] out_q;
  logic [NUM_PINS-1:0] dir_q;
  logic [NUM_PINS-1:0] mask_q;
  logic [NUM_PINS-1:0] cap_q;
  logic [NUM_PINS-1:0] edge_hit;
  logic [NUM_PINS-1:0] src_w;
  logic [NUM_PINS-1:0] rd_sel;
  logic                cap_wr;

  gpio_cap_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_in   (pin_in),
    .q_sync (sync_q),
    .q_prev (prev_q)
  );

  assign cap_wr = bus_wr && (bus_addr == SEL_CAP);

  gpio_cap_event #(.WIDTH(NUM_PINS), .TRIG(TRIG)) u_event (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur      (sync_q),
    .prev     (prev_q),
    .clr_en   (cap_wr),
    .clr_bits (bus_wdata[NUM_PINS-1:0]),
    .hit      (edge_hit),
    .cap_q    (cap_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        SEL_DATA: out_q  <= bus_wdata[NUM_PINS-1:0];
        SEL_DIR:  dir_q  <= bus_wdata[NUM_PINS-1:0];
        SEL_MASK: mask_q <= bus_wdata[NUM_PINS-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      SEL_DATA: rd_sel = sync_q;
      SEL_DIR:  rd_sel = dir_q;
      SEL_MASK: rd_sel = mask_q;
      default:  rd_sel = cap_q;
    endcase
    bus_rdata                 = '0;
    bus_rdata[NUM_PINS-1:0]   = rd_sel;
  end

  assign src_w   = LEVEL_MODE ? sync_q : cap_q;
  assign irq     = |(src_w & mask_q);
  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_capture_port_chk.sv
module gpio_capture_port_chk import gpio_cap_pkg::*; #(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [SEL_W-1:0]    bus_addr,
  input logic [BUS_W-1:0]    bus_wdata,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] cap_q,
  input logic [NUM_PINS-1:0] edge_hit
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && cap_q == '0));

  a_r3_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == SEL_DIR) |=> pin_oe == $past(bus_wdata[NUM_PINS-1:0]));

  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == SEL_CAP)
      |=> ((cap_q & $past(bus_wdata[NUM_PINS-1:0] & ~edge_hit)) == '0));

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((cap_q & $past(edge_hit)) == $past(edge_hit)));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == SEL_CAP) |=> (($past(cap_q) & ~cap_q) == '0));
endmodule

bind gpio_capture_port gpio_capture_port_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_oe    (pin_oe),
  .cap_q     (cap_q),
  .edge_hit  (edge_hit)
);

// File: tb/gpio_capture_port_bench.sv
module gpio_capture_port_bench;
  import gpio_cap_pkg::*;

  localparam int CLK_PERIOD = 20;
  localparam int NP = 8;

  typedef struct {
    int          kind;   // 0..3 rdata of unit k, 4..7 irq of unit k-4, 8 oe, 9 out
    logic [31:0] exp;
    string       req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [NP-1:0] pin_in = '0;

  logic [31:0] rd0, rd1, rd2, rd3;
  logic irq0, irq1, irq2, irq3;
  logic [NP-1:0] out0, out1, out2, out3;
  logic [NP-1:0] oe0, oe1, oe2, oe3;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  item_t sb_q[$];
  event smp;

  always #(CLK_PERIOD/2) clk = ~clk;

  // unit 0: both edges, unit 1: rising, unit 2: falling, unit 3: level
  gpio_capture_port #(.NUM_PINS(NP), .TRIG(TRIG_BOTH)) u_gpio_capture_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd0), .pin_in(pin_in), .pin_out(out0), .pin_oe(oe0), .irq(irq0));
  gpio_capture_port #(.NUM_PINS(NP), .TRIG(TRIG_RISE)) u_gpio_capture_port_rise (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd1), .pin_in(pin_in), .pin_out(out1), .pin_oe(oe1), .irq(irq1));
  gpio_capture_port #(.NUM_PINS(NP), .TRIG(TRIG_FALL)) u_gpio_capture_port_fall (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd2), .pin_in(pin_in), .pin_out(out2), .pin_oe(oe2), .irq(irq2));
  gpio_capture_port #(.NUM_PINS(NP), .TRIG(TRIG_LEVEL)) u_gpio_capture_port_lvl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd3), .pin_in(pin_in), .pin_out(out3), .pin_oe(oe3), .irq(irq3));

  // monitor: pops every queued expectation when the driver signals a sample point
  always @(smp) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0: act = rd0;
        1: act = rd1;
        2: act = rd2;
        3: act = rd3;
        4: act = {31'd0, irq0};
        5: act = {31'd0, irq1};
        6: act = {31'd0, irq2};
        7: act = {31'd0, irq3};
        8: act = {24'd0, oe0};
        default: act = {24'd0, out0};
      endcase
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_wr = 1'b0;
  endtask

  // driver: queue expectations, let the logic settle, then trigger the monitor
  task automatic rd4(input logic [1:0] a, input logic [31:0] e0, input logic [31:0] e1,
                     input logic [31:0] e2, input logic [31:0] e3, input string r);
    bus_addr = a;
    sb_q.push_back('{0, e0, r});
    sb_q.push_back('{1, e1, r});
    sb_q.push_back('{2, e2, r});
    sb_q.push_back('{3, e3, r});
    #1 -> smp;
    #1;
  endtask

  task automatic irq4(input logic e0, input logic e1, input logic e2, input logic e3,
                      input string r);
    sb_q.push_back('{4, {31'd0, e0}, r});
    sb_q.push_back('{5, {31'd0, e1}, r});
    sb_q.push_back('{6, {31'd0, e2}, r});
    sb_q.push_back('{7, {31'd0, e3}, r});
    #1 -> smp;
    #1;
  endtask

  task automatic one(input int k, input logic [31:0] e, input string r);
    sb_q.push_back('{k, e, r});
    #1 -> smp;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1: everything cleared after reset
    for (int a = 0; a < 4; a++) rd4(a[1:0], 0, 0, 0, 0, "R1 reset regs");
    irq4(0, 0, 0, 0, "R1 reset irq");
    one(8, 0, "R1 reset oe");

    // R2/R3: direction, upper bits read zero, oe follows
    wr(SEL_DIR, 32'hFFFF_FFA5);
    rd4(SEL_DIR, 32'hA5, 32'hA5, 32'hA5, 32'hA5, "R2 dir upper bits zero");
    one(8, 32'hA5, "R3 oe follows dir");
    wr(SEL_DATA, 32'hFFFF_FF3C);
    one(9, 32'h3C, "R3 out latch");
    rd4(SEL_DATA, 0, 0, 0, 0, "R4 data reads pins not latch");

    // R4/R5: synchronizer latency and rising capture
    pin_in = 8'h01;
    step(1);
    rd4(SEL_DATA, 0, 0, 0, 0, "R4 not visible after one edge");
    step(1);
    rd4(SEL_DATA, 1, 1, 1, 1, "R4 visible after two edges");
    rd4(SEL_CAP, 0, 0, 0, 0, "R5 capture not yet set");
    step(1);
    rd4(SEL_CAP, 1, 1, 0, 0, "R5 R6 rise captured");
    irq4(0, 0, 0, 0, "R9 R10 masked");

    // R9/R10: enabling
    wr(SEL_MASK, 32'hFFFF_FFFF);
    rd4(SEL_MASK, 32'hFF, 32'hFF, 32'hFF, 32'hFF, "R2 mask upper bits zero");
    irq4(1, 1, 0, 1, "R9 R10 enabled");

    // R7/R10: clear bit 0; level unit ignores the write
    wr(SEL_CAP, 32'h1);
    rd4(SEL_CAP, 0, 0, 0, 0, "R7 R10 clear bit0");
    irq4(0, 0, 0, 1, "R9 R10 after clear");

    // R5/R6: falling edge
    pin_in = 8'h00;
    step(3);
    rd4(SEL_CAP, 1, 0, 1, 0, "R5 R6 fall captured");
    irq4(1, 0, 1, 0, "R9 R10 after fall");

    // R7: partial clear
    wr(SEL_CAP, 32'hFF);
    pin_in = 8'h06;
    step(3);
    rd4(SEL_CAP, 32'h06, 32'h06, 0, 0, "R6 two pins rise");
    wr(SEL_CAP, 32'h02);
    rd4(SEL_CAP, 32'h04, 32'h04, 0, 0, "R7 only written ones clear");

    // R9/R10: partial enable hides but keeps capture
    wr(SEL_MASK, 32'h02);
    irq4(0, 0, 0, 1, "R9 R10 partial mask");
    rd4(SEL_CAP, 32'h04, 32'h04, 0, 0, "R9 masked bit stays captured");

    // R8: clear write coincides with a new capture on bit 3
    pin_in = 8'h0E;
    step(2);
    wr(SEL_CAP, 32'h08);
    rd4(SEL_CAP, 32'h0C, 32'h0C, 0, 0, "R8 set beats clear");
    wr(SEL_CAP, 32'h08);
    rd4(SEL_CAP, 32'h04, 32'h04, 0, 0, "R7 later clear takes effect");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule